// File: doc/BRIEF.md
# Instruction Decode Unit

This block decodes one fixed-width 32-bit instruction word per cycle for a load/store machine with sixteen 32-bit general registers. The top 8 bits select the operation and the lower 24 bits are an operand segment whose meaning depends on the operation. The decoder sorts each opcode into a class and pulls out the register indices, the immediate and the memory address. It then raises the register-write and memory strobes that the rest of the pipeline acts on.

Two opcode groups of sixteen carry their register inside the opcode. One group loads a register from memory and the other stores a register to memory. Each takes the full 24-bit operand as the address. A block of register-immediate opcodes holds two 4-bit register fields and a 16-bit signed immediate. A jump opcode takes all 24 operand bits as an unsigned immediate. Every other opcode is reported as illegal. All outputs are registered, so a decoded result appears one cycle after its strobe. No result appears for a cycle without a strobe.

Top module: `insn_dec_top`

## Requirements
- R1: `outValid` equals `inValid` of the previous cycle. A cycle with `inValid` low yields `outValid`, `outRegWrite`, `outMemRead`, `outMemWrite` and `outIllegal` all low in the next cycle.
- R2: Opcode bits 31:24 in 0x00..0x0F decode as a load. The result has class code 1, `outDst` = opcode bits 3:0, `outAddr` = instruction bits 23:0, and `outMemRead` and `outRegWrite` high. Sources and immediate are zero.
- R3: Opcodes 0x10..0x1F decode as a store. The result has class code 2, `outSrcB` = opcode bits 3:0, `outAddr` = instruction bits 23:0, and `outMemWrite` high with `outRegWrite` low. `outDst`, `outSrcA` and the immediate are zero.
- R4: Opcodes 0x20..0x27 decode as register-immediate with class code 3. `outDst` = bits 23:20, `outSrcA` = bits 19:16, `outImm` = bits 15:0 sign-extended to 32 bits, and `outRegWrite` high. There is no memory strobe and the address is zero.
- R5: Opcode 0x30 decodes as a jump with class code 4. `outImm` = bits 23:0 zero-extended, and no write or memory strobe is raised.
- R6: Any other opcode raises `outIllegal` for exactly the one cycle of its result. That result has class code 0, all strobes low and all fields zero.
- R7: Only loads and stores raise a memory strobe, and `outMemRead` and `outMemWrite` are never high together.
- R8: A high synchronous reset clears every output to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Instruction strobe |
| inInsn | input | 32 | Instruction word |
| outValid | output | 1 | Decoded result valid |
| outClass | output | 3 | Operation class code (0 none/illegal, 1 load, 2 store, 3 reg-imm, 4 jump) |
| outDst | output | 4 | Destination register index |
| outSrcA | output | 4 | First source register index |
| outSrcB | output | 4 | Second source register index (store data) |
| outImm | output | 32 | Extended immediate |
| outAddr | output | 24 | Memory address |
| outRegWrite | output | 1 | Register write enable |
| outMemRead | output | 1 | Memory read request |
| outMemWrite | output | 1 | Memory write request |
| outIllegal | output | 1 | Unassigned opcode flag |

## Verification
The bench targets the edges of each opcode group: 0x0F against 0x10, 0x1F against 0x20, 0x27 against 0x28, and 0x30 against 0x2F and 0x31. A decoder with an off-by-one group boundary would misclassify one of these opcodes or accept an illegal one. Immediates with bit 15 set and clear expose missing or wrong sign extension. All-ones and minimal addresses expose a truncated address path. Directed cases check that an illegal flag is gone in the following legal cycle, that an instruction presented without a strobe leaves no strobe behind, and that a reset in mid-stream discards the pending result instead of emitting it.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int INSN_W     = 32;
  localparam int OPC_W      = 8;
  localparam int REG_W      = 4;
  localparam int HALF_IMM_W = 16;
  localparam int DATA_W     = 32;
  localparam int OPERAND_W  = INSN_W - OPC_W;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_LOAD  = 3'd1,
    CLS_STORE = 3'd2,
    CLS_ALU   = 3'd3,
    CLS_JUMP  = 3'd4
  } opClass_e;

  typedef enum logic [1:0] {
    FMT_NONE,
    FMT_ADDR,
    FMT_REGIMM,
    FMT_WIDEIMM
  } opFormat_e;

  typedef struct packed {
    opClass_e  cls;
    opFormat_e fmt;
    logic      dstFromOpc;
    logic      srcFromOpc;
    logic      regWe;
    logic      memRd;
    logic      memWr;
    logic      illegal;
  } decStrobes_t;
endpackage

// File: rtl/insn_dec_ctrl.sv
module insn_dec_ctrl
  import insn_dec_pkg::*;
#(
  parameter logic [OPC_W-1:0] LOAD_BASE  = 8'h00,
  parameter logic [OPC_W-1:0] STORE_BASE = 8'h10,
  parameter logic [OPC_W-1:0] ALU_BASE   = 8'h20,
  parameter int               ALU_COUNT  = 8,
  parameter logic [OPC_W-1:0] JUMP_OPC   = 8'h30
) (
  input  logic [OPC_W-1:0] opcode,
  output decStrobes_t      strobes
);
  localparam int GRP_W = OPC_W - REG_W;
  localparam logic [GRP_W-1:0] LOAD_GRP  = LOAD_BASE[OPC_W-1:REG_W];
  localparam logic [GRP_W-1:0] STORE_GRP = STORE_BASE[OPC_W-1:REG_W];
  localparam int ALU_LO = int'(ALU_BASE);
  localparam int ALU_HI = ALU_LO + ALU_COUNT;

  logic isLoad, isStore, isAlu, isJump;
  int   opcodeNum;

  always_comb begin
    opcodeNum = int'(opcode);
    isLoad  = (opcode[OPC_W-1:REG_W] == LOAD_GRP);
    isStore = (opcode[OPC_W-1:REG_W] == STORE_GRP);
    isAlu   = (opcodeNum >= ALU_LO) && (opcodeNum < ALU_HI);
    isJump  = (opcode == JUMP_OPC);
  end

  always_comb begin
    strobes = '0;
    if (isLoad) begin
      strobes.cls        = CLS_LOAD;
      strobes.fmt        = FMT_ADDR;
      strobes.dstFromOpc = 1'b1;
      strobes.regWe      = 1'b1;
      strobes.memRd      = 1'b1;
    end else if (isStore) begin
      strobes.cls        = CLS_STORE;
      strobes.fmt        = FMT_ADDR;
      strobes.srcFromOpc = 1'b1;
      strobes.memWr      = 1'b1;
    end else if (isAlu) begin
      strobes.cls   = CLS_ALU;
      strobes.fmt   = FMT_REGIMM;
      strobes.regWe = 1'b1;
    end else if (isJump) begin
      strobes.cls = CLS_JUMP;
      strobes.fmt = FMT_WIDEIMM;
    end else begin
      strobes.illegal = 1'b1;
    end
  end
endmodule

// File: rtl/insn_dec_datapath.sv
module insn_dec_datapath
  import insn_dec_pkg::*;
#(
  parameter bit IMM_SIGNED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [INSN_W-1:0]    inInsn,
  input  decStrobes_t          strobes,
  output logic                 outValid,
  output logic [2:0]           outClass,
  output logic [REG_W-1:0]     outDst,
  output logic [REG_W-1:0]     outSrcA,
  output logic [REG_W-1:0]     outSrcB,
  output logic [DATA_W-1:0]    outImm,
  output logic [OPERAND_W-1:0] outAddr,
  output logic                 outRegWrite,
  output logic                 outMemRead,
  output logic                 outMemWrite,
  output logic                 outIllegal
);
  localparam int EXT_W  = DATA_W - HALF_IMM_W;
  localparam int WIDE_W = DATA_W - OPERAND_W;

  logic [OPERAND_W-1:0]  operand;
  logic [REG_W-1:0]      opcReg, fieldA, fieldB;
  logic [HALF_IMM_W-1:0] immHalf;
  logic [DATA_W-1:0]     immExt;

  assign operand = inInsn[OPERAND_W-1:0];
  assign opcReg  = inInsn[OPERAND_W +: REG_W];
  assign fieldA  = operand[OPERAND_W-1 -: REG_W];
  assign fieldB  = operand[OPERAND_W-1-REG_W -: REG_W];
  assign immHalf = operand[HALF_IMM_W-1:0];

  generate
    if (IMM_SIGNED) begin : g_signExt
      assign immExt = {{EXT_W{immHalf[HALF_IMM_W-1]}}, immHalf};
    end else begin : g_zeroExt
      assign immExt = {{EXT_W{1'b0}}, immHalf};
    end
  endgenerate

  logic [2:0]           nClass;
  logic [REG_W-1:0]     nDst, nSrcA, nSrcB;
  logic [DATA_W-1:0]    nImm;
  logic [OPERAND_W-1:0] nAddr;
  logic                 nRegWe, nMemRd, nMemWr, nIllegal;

  always_comb begin
    nClass   = '0;
    nDst     = '0;
    nSrcA    = '0;
    nSrcB    = '0;
    nImm     = '0;
    nAddr    = '0;
    nRegWe   = 1'b0;
    nMemRd   = 1'b0;
    nMemWr   = 1'b0;
    nIllegal = 1'b0;
    if (inValid) begin
      nClass   = strobes.cls;
      nRegWe   = strobes.regWe;
      nMemRd   = strobes.memRd;
      nMemWr   = strobes.memWr;
      nIllegal = strobes.illegal;
      case (strobes.fmt)
        FMT_ADDR: begin
          nAddr = operand;
          if (strobes.dstFromOpc) nDst = opcReg;
          if (strobes.srcFromOpc) nSrcB = opcReg;
        end
        FMT_REGIMM: begin
          nDst  = fieldA;
          nSrcA = fieldB;
          nImm  = immExt;
        end
        FMT_WIDEIMM: nImm = {{WIDE_W{1'b0}}, operand};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid    <= 1'b0;
      outClass    <= '0;
      outDst      <= '0;
      outSrcA     <= '0;
      outSrcB     <= '0;
      outImm      <= '0;
      outAddr     <= '0;
      outRegWrite <= 1'b0;
      outMemRead  <= 1'b0;
      outMemWrite <= 1'b0;
      outIllegal  <= 1'b0;
    end else begin
      outValid    <= inValid;
      outClass    <= nClass;
      outDst      <= nDst;
      outSrcA     <= nSrcA;
      outSrcB     <= nSrcB;
      outImm      <= nImm;
      outAddr     <= nAddr;
      outRegWrite <= nRegWe;
      outMemRead  <= nMemRd;
      outMemWrite <= nMemWr;
      outIllegal  <= nIllegal;
    end
  end
endmodule

// File: rtl/insn_dec_top.sv
module insn_dec_top
  import insn_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [31:0] inInsn,
  output logic        outValid,
  output logic [2:0]  outClass,
  output logic [3:0]  outDst,
  output logic [3:0]  outSrcA,
  output logic [3:0]  outSrcB,
  output logic [31:0] outImm,
  output logic [23:0] outAddr,
  output logic        outRegWrite,
  output logic        outMemRead,
  output logic        outMemWrite,
  output logic        outIllegal
);
  decStrobes_t strobes;

  insn_dec_ctrl u_ctrl (
    .opcode  (inInsn[INSN_W-1 -: OPC_W]),
    .strobes (strobes)
  );

  insn_dec_datapath u_dp (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .inInsn      (inInsn),
    .strobes     (strobes),
    .outValid    (outValid),
    .outClass    (outClass),
    .outDst      (outDst),
    .outSrcA     (outSrcA),
    .outSrcB     (outSrcB),
    .outImm      (outImm),
    .outAddr     (outAddr),
    .outRegWrite (outRegWrite),
    .outMemRead  (outMemRead),
    .outMemWrite (outMemWrite),
    .outIllegal  (outIllegal)
  );
endmodule

// File: rtl/insn_dec_chk.sv
module insn_dec_chk (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic       outValid,
  input logic [2:0] outClass,
  input logic       outRegWrite,
  input logic       outMemRead,
  input logic       outMemWrite,
  input logic       outIllegal
);
  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> !(outRegWrite || outMemRead || outMemWrite || outIllegal));
  // R6
  illegal_inert_chk: assert property (@(posedge clk) disable iff (rst)
    outIllegal |-> (!outRegWrite && !outMemRead && !outMemWrite && outClass == 3'd0));
  // R7
  mem_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(outMemRead && outMemWrite));
  // R7
  mem_class_chk: assert property (@(posedge clk) disable iff (rst)
    (outMemRead || outMemWrite) |-> (outClass == 3'd1 || outClass == 3'd2));
  // R2
  load_writes_chk: assert property (@(posedge clk) disable iff (rst)
    outMemRead |-> outRegWrite);
endmodule

bind insn_dec_top insn_dec_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .inValid     (inValid),
  .outValid    (outValid),
  .outClass    (outClass),
  .outRegWrite (outRegWrite),
  .outMemRead  (outMemRead),
  .outMemWrite (outMemWrite),
  .outIllegal  (outIllegal)
);

// File: tb/insn_dec_top_test.sv
module insn_dec_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inInsn = '0;
  logic        outValid, outRegWrite, outMemRead, outMemWrite, outIllegal;
  logic [2:0]  outClass;
  logic [3:0]  outDst, outSrcA, outSrcB;
  logic [31:0] outImm;
  logic [23:0] outAddr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  insn_dec_top uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inInsn(inInsn),
    .outValid(outValid), .outClass(outClass), .outDst(outDst),
    .outSrcA(outSrcA), .outSrcB(outSrcB), .outImm(outImm),
    .outAddr(outAddr), .outRegWrite(outRegWrite), .outMemRead(outMemRead),
    .outMemWrite(outMemWrite), .outIllegal(outIllegal)
  );

  typedef struct packed {
    logic [31:0] insn;
    logic [2:0]  cls;
    logic [3:0]  dst;
    logic [3:0]  srcA;
    logic [3:0]  srcB;
    logic [31:0] imm;
    logic [23:0] addr;
    logic        we;
    logic        rd;
    logic        wr;
    logic        ill;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{32'h05ABCDEF, 3'd1, 4'h5, 4'h0, 4'h0, 32'h00000000, 24'hABCDEF, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h0F000000, 3'd1, 4'hF, 4'h0, 4'h0, 32'h00000000, 24'h000000, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h00FFFFFF, 3'd1, 4'h0, 4'h0, 4'h0, 32'h00000000, 24'hFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h1A123456, 3'd2, 4'h0, 4'h0, 4'hA, 32'h00000000, 24'h123456, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'h10000001, 3'd2, 4'h0, 4'h0, 4'h0, 32'h00000000, 24'h000001, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'h1FFEDCBA, 3'd2, 4'h0, 4'h0, 4'hF, 32'h00000000, 24'hFEDCBA, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'h2137FFFF, 3'd3, 4'h3, 4'h7, 4'h0, 32'hFFFFFFFF, 24'h000000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h27A87FFF, 3'd3, 4'hA, 4'h8, 4'h0, 32'h00007FFF, 24'h000000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h20008000, 3'd3, 4'h0, 4'h0, 4'h0, 32'hFFFF8000, 24'h000000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h30ABCDEF, 3'd4, 4'h0, 4'h0, 4'h0, 32'h00ABCDEF, 24'h000000, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h28000000, 3'd0, 4'h0, 4'h0, 4'h0, 32'h00000000, 24'h000000, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'h2F123456, 3'd0, 4'h0, 4'h0, 4'h0, 32'h00000000, 24'h000000, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'h31FFFFFF, 3'd0, 4'h0, 4'h0, 4'h0, 32'h00000000, 24'h000000, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'hFF123456, 3'd0, 4'h0, 4'h0, 4'h0, 32'h00000000, 24'h000000, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  function automatic string tagOf(vec_t e);
    if (e.ill) return "R6";
    case (e.cls)
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      3'd4:    return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic vec_t actual(logic [31:0] insn);
    return '{insn, outClass, outDst, outSrcA, outSrcB, outImm, outAddr,
             outRegWrite, outMemRead, outMemWrite, outIllegal};
  endfunction

  task automatic checkBundle(vec_t e, logic expValid, string tag);
    vec_t a = actual(e.insn);
    checks++;
    if (a !== e || outValid !== expValid) begin
      fails++;
      $display("FAIL %s insn=%h actual=%h valid=%b expected=%h valid=%b",
               tag, e.insn, a, outValid, e, expValid);
    end
  endtask

  task automatic checkMemExclusive(logic [31:0] insn);
    checks++;
    if (outMemRead && outMemWrite) begin
      fails++;
      $display("FAIL R7 insn=%h actual rd=%b wr=%b expected not both",
               insn, outMemRead, outMemWrite);
    end
  endtask

  vec_t zeroVec;

  initial begin
    zeroVec = '0;
    // R8: outputs cleared while reset is held
    repeat (3) @(negedge clk);
    checkBundle(zeroVec, 1'b0, "R8");
    rst = 1'b0;

    // R1: instruction without strobe leaves nothing behind
    inInsn = 32'h05ABCDEF;
    inValid = 1'b0;
    @(negedge clk);
    checkBundle(zeroVec, 1'b0, "R1");

    // R1: result not visible before the next edge
    inValid = 1'b1;
    #1;
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 early valid actual=%b expected=0", outValid);
    end

    // streamed table vectors, one per cycle
    for (int i = 0; i < NVEC; i++) begin
      inInsn  = VECS[i].insn;
      inValid = 1'b1;
      @(negedge clk);
      checkBundle(VECS[i], 1'b1, tagOf(VECS[i]));
      checkMemExclusive(VECS[i].insn);
    end

    // R6: illegal flag lasts only for its own cycle
    inInsn = 32'h2F000000;
    @(negedge clk);
    inInsn = 32'h0300000A;
    @(negedge clk);
    checkBundle('{32'h0300000A, 3'd1, 4'h3, 4'h0, 4'h0, 32'h0, 24'h00000A,
                  1'b1, 1'b1, 1'b0, 1'b0}, 1'b1, "R6");

    // R1: strobe drops, next cycle quiet
    inValid = 1'b0;
    inInsn  = 32'h1A123456;
    @(negedge clk);
    checkBundle(zeroVec, 1'b0, "R1");

    // R8: reset mid-stream discards the pending result
    inValid = 1'b1;
    inInsn  = 32'h05ABCDEF;
    rst = 1'b1;
    @(negedge clk);
    checkBundle(zeroVec, 1'b0, "R8");
    rst = 1'b0;
    inValid = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule